// File: doc/BRIEF.md
# Exact-Change Coin Vending Controller

This block is the control state machine of a single-slot package dispenser. The slot sensing logic raises one-cycle strobes for three coin types: 5 cents, 10 cents and 25 cents. The controller keeps the running credit as a state and releases one package once the deposit adds up to exactly 25 cents. Pennies have no input and are never counted.

Because the machine gives no change, the credit can never rise above the price. A coin that would overshoot the price is refused and the credit stays as it was. A cycle in which more than one strobe is raised is treated as a sensing fault, and every coin in that cycle is refused.

Both outputs come from flip-flops. The dispense pulse and the refuse pulse each appear for one cycle, on the cycle after the strobe that caused them. The credit is counted in units of the smallest coin, 5 cents, so the only credit levels are 0, 5, 10, 15 and 20 cents.

Top module: `vend_ctrl`

## Requirements
- R1: A single accepted strobe adds its value to the credit: `nickel_i` adds 5 cents, `dime_i` adds 10 cents and `quarter_i` adds 25 cents. Between coin events the credit is one of 0, 5, 10, 15 or 20 cents.
- R2: When a single coin makes the credit exactly 25 cents, `vend_o` is high for exactly one cycle, on the cycle after the strobe, and the credit returns to 0 on that same clock edge.
- R3: A single coin that would push the credit above 25 cents raises `refuse_o` for one cycle, on the cycle after the strobe, and leaves the credit unchanged.
- R4: When two or three strobes are high in the same cycle, `refuse_o` is high on the next cycle, `vend_o` stays low and the credit is unchanged.
- R5: A cycle with no strobe leaves both outputs low on the next cycle and holds the credit.
- R6: `rst` is synchronous and active high. On every clock edge where it is high, the credit goes to 0 and both outputs go low. Strobes raised during reset are ignored.
- R7: `vend_o` and `refuse_o` are never high in the same cycle. Each coin event produces at most one single-cycle pulse.
- R8: A quarter inserted while the credit is 0 dispenses on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Everything is sampled on the rising edge. |
| rst | input | 1 | Synchronous reset, active high |
| nickel_i | input | 1 | One-cycle strobe for a 5-cent coin |
| dime_i | input | 1 | One-cycle strobe for a 10-cent coin |
| quarter_i | input | 1 | One-cycle strobe for a 25-cent coin |
| vend_o | output | 1 | One-cycle pulse that releases one package |
| refuse_o | output | 1 | One-cycle pulse that rejects the coin or coins of the previous cycle |

## Verification
Each result is due exactly one cycle after its stimulus. The strobes are driven on the falling edge. The registered pulse then appears on the next rising edge and is sampled one time unit later.

The driver pushes the expected pulse pair for every driven cycle into a queue. The monitor pops one entry after each rising edge, so every cycle is checked, idle cycles included, and a pulse that comes early or late shows as a mismatch.

The credit is not visible at the ports. Where a refusal, a multi-strobe cycle or a reset must leave it unchanged or cleared, the bench proves the remaining credit by adding coins afterwards and checking on which coin the dispense pulse appears.

// File: rtl/vend_pkg.sv
package vend_pkg;

    // Classified content of one cycle of the coin slot
    typedef enum logic [2:0] {
        COIN_NONE    = 3'd0,
        COIN_NICKEL  = 3'd1,
        COIN_DIME    = 3'd2,
        COIN_QUARTER = 3'd3,
        COIN_MULTI   = 3'd4
    } coin_kind_e;

endpackage

// File: rtl/vend_coin_sel.sv
module vend_coin_sel
    import vend_pkg::*;
(
    input  logic       nickel_i,
    input  logic       dime_i,
    input  logic       quarter_i,
    output coin_kind_e kind_o
);

    always_comb begin
        unique case ({quarter_i, dime_i, nickel_i})
            3'b000:  kind_o = COIN_NONE;
            3'b001:  kind_o = COIN_NICKEL;
            3'b010:  kind_o = COIN_DIME;
            3'b100:  kind_o = COIN_QUARTER;
            default: kind_o = COIN_MULTI;
        endcase
    end

endmodule

// File: rtl/vend_credit_fsm.sv
module vend_credit_fsm
    import vend_pkg::*;
#(
    parameter int LEVELS    = 5,
    parameter int NICKEL_U  = 1,
    parameter int DIME_U    = 2,
    parameter int QUARTER_U = 5,
    parameter int LVL_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  coin_kind_e       kind_i,
    output logic [LVL_W-1:0] credit_o,
    output logic             vend_o,
    output logic             refuse_o
);

    localparam int MAX_U = (QUARTER_U > DIME_U) ?
                           ((QUARTER_U > NICKEL_U) ? QUARTER_U : NICKEL_U) :
                           ((DIME_U > NICKEL_U) ? DIME_U : NICKEL_U);
    localparam int SUM_W = $clog2(LEVELS + MAX_U + 1);

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic             vend;
        logic             refuse;
    } st_t;

    st_t             st_d, st_q;
    logic [SUM_W-1:0] add_units;
    logic [SUM_W-1:0] sum_units;

    always_comb begin
        st_d        = st_q;
        st_d.vend   = 1'b0;
        st_d.refuse = 1'b0;
        add_units   = '0;
        unique case (kind_i)
            COIN_NICKEL:  add_units = SUM_W'(NICKEL_U);
            COIN_DIME:    add_units = SUM_W'(DIME_U);
            COIN_QUARTER: add_units = SUM_W'(QUARTER_U);
            default:      add_units = '0;
        endcase
        sum_units = SUM_W'(st_q.lvl) + add_units;

        if (kind_i == COIN_MULTI) begin
            st_d.refuse = 1'b1;
        end else if (kind_i != COIN_NONE) begin
            if (sum_units == SUM_W'(LEVELS)) begin
                st_d.vend = 1'b1;
                st_d.lvl  = '0;
            end else if (sum_units > SUM_W'(LEVELS)) begin
                st_d.refuse = 1'b1;
            end else begin
                st_d.lvl = LVL_W'(sum_units);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign credit_o = st_q.lvl;
    assign vend_o   = st_q.vend;
    assign refuse_o = st_q.refuse;

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter int PRICE_C   = 25,
    parameter int UNIT_C    = 5,
    parameter int NICKEL_C  = 5,
    parameter int DIME_C    = 10,
    parameter int QUARTER_C = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic nickel_i,
    input  logic dime_i,
    input  logic quarter_i,
    output logic vend_o,
    output logic refuse_o
);

    localparam int LEVELS = PRICE_C / UNIT_C;
    localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;

    coin_kind_e       kind;
    logic [LVL_W-1:0] credit_lvl;

    vend_coin_sel u_sel (
        .nickel_i  (nickel_i),
        .dime_i    (dime_i),
        .quarter_i (quarter_i),
        .kind_o    (kind)
    );

    vend_credit_fsm #(
        .LEVELS    (LEVELS),
        .NICKEL_U  (NICKEL_C / UNIT_C),
        .DIME_U    (DIME_C / UNIT_C),
        .QUARTER_U (QUARTER_C / UNIT_C),
        .LVL_W     (LVL_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .kind_i   (kind),
        .credit_o (credit_lvl),
        .vend_o   (vend_o),
        .refuse_o (refuse_o)
    );

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
    parameter int LEVELS = 5,
    parameter int LVL_W  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             nickel_i,
    input logic             dime_i,
    input logic             quarter_i,
    input logic             vend_o,
    input logic             refuse_o,
    input logic [LVL_W-1:0] credit_lvl
);

    // R7
    no_dual_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !(vend_o && refuse_o));

    // R1
    credit_range_chk: assert property (@(posedge clk) disable iff (rst)
        credit_lvl < LVL_W'(LEVELS));

    // R4
    multi_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones({quarter_i, dime_i, nickel_i}) > 1) |=> (refuse_o && !vend_o));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ({quarter_i, dime_i, nickel_i} == 3'b000) |=>
            (!vend_o && !refuse_o && $stable(credit_lvl)));

    // R3
    refuse_hold_chk: assert property (@(posedge clk) disable iff (rst)
        refuse_o |-> (credit_lvl == $past(credit_lvl)));

    // R2
    vend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        vend_o |-> (credit_lvl == '0));

    // R8
    quarter_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (quarter_i && !dime_i && !nickel_i && credit_lvl == '0) |=> vend_o);

endmodule

bind vend_ctrl vend_ctrl_chk #(
    .LEVELS (LEVELS),
    .LVL_W  (LVL_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .nickel_i   (nickel_i),
    .dime_i     (dime_i),
    .quarter_i  (quarter_i),
    .vend_o     (vend_o),
    .refuse_o   (refuse_o),
    .credit_lvl (credit_lvl)
);

// File: tb/tb_vend_ctrl.sv
module tb_vend_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int PRICE      = 25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel_i = 1'b0;
    logic dime_i = 1'b0;
    logic quarter_i = 1'b0;
    logic vend_o;
    logic refuse_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    int model_credit = 0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vend_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .nickel_i  (nickel_i),
        .dime_i    (dime_i),
        .quarter_i (quarter_i),
        .vend_o    (vend_o),
        .refuse_o  (refuse_o)
    );

    // Driver: one cycle of stimulus plus the expected {vend, refuse} pair
    task automatic step(input bit r, input bit n, input bit d, input bit q, input string tag);
        int cnt;
        int val;
        logic [1:0] e;
        @(negedge clk);
        rst = r; nickel_i = n; dime_i = d; quarter_i = q;
        cnt = int'(n) + int'(d) + int'(q);
        val = n ? 5 : (d ? 10 : 25);
        e = 2'b00;
        if (r) begin
            model_credit = 0;
        end else if (cnt > 1) begin
            e = 2'b01;
        end else if (cnt == 1) begin
            if (model_credit + val == PRICE) begin
                e = 2'b10;
                model_credit = 0;
            end else if (model_credit + val > PRICE) begin
                e = 2'b01;
            end else begin
                model_credit = model_credit + val;
            end
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // Monitor: result of each driven cycle is due right after the next rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if ({vend_o, refuse_o} !== e) begin
                    bad++;
                    $display("FAIL %s: got vend=%b refuse=%b expected vend=%b refuse=%b",
                             t, vend_o, refuse_o, e[1], e[0]);
                end
            end
        end
    end

    initial begin
        // reset, with a strobe raised during reset
        step(1'b1, 1'b0, 1'b0, 1'b0, "R6 reset");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R6 strobe ignored in reset");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R6 strobe ignored in reset");
        idle("R5 idle after reset");
        idle("R5 idle");
        // five nickels
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, 1'b0, "R1 nickel run / R2 vend");
        idle("R7 single-cycle vend");
        // dime dime nickel
        step(1'b0, 1'b0, 1'b1, 1'b0, "R1 dime");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R1 dime");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R2 vend at 25");
        // quarter at zero credit, back to back
        step(1'b0, 1'b0, 0, 1'b1, "R8 quarter from zero");
        step(1'b0, 1'b0, 0, 1'b1, "R8 quarter again");
        idle("R7 pulse ends");
        // overshoot with a quarter at 5 cents
        step(1'b0, 1'b1, 1'b0, 1'b0, "R1 nickel");
        step(1'b0, 1'b0, 1'b0, 1'b1, "R3 quarter refused at 5");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R3 credit kept");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R3 vend proves credit kept");
        // overshoot with a dime at 20 cents
        step(1'b0, 1'b0, 1'b1, 1'b0, "R1 dime");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R1 dime");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R3 dime refused at 20");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R3 nickel completes 25");
        // two strobes at zero credit
        step(1'b0, 1'b1, 1'b1, 1'b0, "R4 two strobes refused");
        step(1'b0, 1'b0, 1'b0, 1'b1, "R4 credit still zero");
        // three strobes at 5 cents
        step(1'b0, 1'b1, 1'b0, 1'b0, "R1 nickel");
        step(1'b0, 1'b1, 1'b1, 1'b1, "R4 three strobes refused");
        step(1'b0, 1'b0, 1'b1, 1'b1, "R4 dime+quarter refused");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R4 credit kept");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R4 vend proves credit kept");
        // hold 15 cents across idle cycles
        step(1'b0, 1'b0, 1'b1, 1'b0, "R1 dime");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R1 nickel");
        idle("R5 hold");
        idle("R5 hold");
        idle("R5 hold");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R5 vend proves credit held");
        // reset clears 20 cents
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 1'b0, "R1 nickel");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R6 reset mid credit");
        step(1'b0, 1'b0, 1'b0, 1'b1, "R6 credit cleared");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R1 nickel");
        idle("R7 idle");
        idle("R7 idle");
        repeat (3) @(posedge clk);
        #2;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule